// File: doc/BRIEF.md
# Divide-by-Twelve Counter with Modulo-Six Upper Stage

This block is a four-bit counter made of two sections, each advanced by its own count input. The low section is a single toggle bit (Q0). The high section (Q3..Q1) is a modulo-six stage that does not count in binary. Within it, Q1 and Q2 form a divide-by-three, and Q3 changes state once every third step of that stage. Both count inputs are asynchronous to the system clock. Each one passes through a synchronizer, and the section moves forward when the synchronized copy shows a high-to-low transition.

A mode input picks the topology. With mode 0 the two sections run independently, one clocked by each count input. With mode 1 the falling edge of Q0 drives the upper stage, so the four bits form a modulo-12 counter whose Q3 is a symmetric square wave at one twelfth of the low-section input rate. A clear formed from two inputs ANDed together takes priority over counting. A terminal-count flag marks the last state of the chained sequence.

Top module: `div12_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0000 and `tc_o` is 0.
- R2: Q0 (`q_o[0]`) toggles once for each high-to-low transition of `cnt_a_i`. The new value appears on the third rising `clk_i` edge after the input falls, and never earlier. A low-to-high transition of `cnt_a_i` changes nothing.
- R3: With `chain_i` = 0, each falling edge of `cnt_b_i` steps `q_o[3:1]` (bit order Q3 Q2 Q1) through 000, 001, 010, 100, 101, 110, after which it returns to 000. The timing is the same as in R2.
- R4: With `chain_i` = 0, Q0 moves only on `cnt_a_i` and the upper stage moves only on `cnt_b_i`. With `chain_i` = 1, `cnt_b_i` has no effect.
- R5: With `chain_i` = 1, each falling edge of `cnt_a_i` advances `q_o` through 0000, 0001, 0010, 0011, 0100, 0101, 1000, 1001, 1010, 1011, 1100, 1101 and then back to 0000. When Q0 falls, the upper stage steps on the same clock edge.
- R6: With `chain_i` = 1 and counting from 0000, Q3 is low for six consecutive counts and then high for the next six.
- R7: When `clr_a_i` and `clr_b_i` are both high at a rising `clk_i` edge, all four bits are 0000 after that edge, and count edges arriving during the clear are lost. When only one of the two is high, the state does not change.
- R8: `tc_o` is high exactly when `chain_i` = 1 and `q_o` = 1101. It is combinational in `chain_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_i | input | 1 | Count input of the toggle stage (falling edge counts) |
| cnt_b_i | input | 1 | Count input of the upper stage in independent mode |
| clr_a_i | input | 1 | Clear enable, first leg |
| clr_b_i | input | 1 | Clear enable, second leg |
| chain_i | input | 1 | 0 = independent stages, 1 = chained modulo-12 |
| q_o | output | 4 | Counter state, Q3..Q0 |
| tc_o | output | 1 | Terminal count (chained state 1101) |

## Verification
The assertions assume two things about the inputs. Each count input must hold every level for at least as many system clocks as the synchronizer has stages, so that each edge is seen exactly once. `chain_i` must not change in the same cycle that a detected edge is being applied. The stimulus holds each count level for four clocks and changes the mode only while the count inputs are idle. Under those conditions every count reaches the state, and the expected codes are derived from the step index alone: Q1 and Q2 come from the index modulo three, and Q3 from whether the index is at least three.

// File: rtl/div12_pkg.sv
package div12_pkg;

    // Upper (modulo-six) stage: bit 0 = Q1, bit 1 = Q2, bit 2 = Q3
    typedef struct packed {
        logic [2:0] code;
    } hex_state_t;

    typedef struct packed {
        logic bit_q;
    } tog_state_t;

    localparam logic [3:0] LAST_CHAINED = 4'b1101;

endpackage

// File: rtl/div12_fall_det.sv
module div12_fall_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic din_i,
    output logic fall_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // previous synchronized level high, current low
    assign fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
endmodule

// File: rtl/div12_toggle_stage.sv
module div12_toggle_stage
    import div12_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic bit_o,
    output logic carry_o
);
    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)       st_d.bit_q = 1'b0;
        else if (step_i) st_d.bit_q = ~st_q.bit_q;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o   = st_q.bit_q;
    // this step drives the bit from 1 to 0
    assign carry_o = step_i & st_q.bit_q & ~clr_i;
endmodule

// File: rtl/div12_hex_stage.sv
module div12_hex_stage
    import div12_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       step_i,
    output logic [2:0] code_o
);
    hex_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.code = 3'b000;
        end else if (step_i) begin
            unique case (st_q.code[1:0])
                2'b00:   st_d.code = {st_q.code[2], 2'b01};
                2'b01:   st_d.code = {st_q.code[2], 2'b10};
                2'b10:   st_d.code = {~st_q.code[2], 2'b00};
                default: st_d.code = 3'b000; // unused codes recover to zero
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/div12_counter.sv
module div12_counter
    import div12_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_n,
    input  logic       cnt_a_i,
    input  logic       cnt_b_i,
    input  logic       clr_a_i,
    input  logic       clr_b_i,
    input  logic       chain_i,
    output logic [3:0] q_o,
    output logic       tc_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_w;
    logic [N_IN-1:0] fall_w;
    logic            fall_a_w;
    logic            fall_b_w;
    logic            clr_w;
    logic            carry_w;
    logic            up_step_w;
    logic            q0_w;
    logic [2:0]      up_w;

    assign raw_w = {cnt_b_i, cnt_a_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_det
        div12_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk_i (clk_i),
            .rst_n (rst_n),
            .din_i (raw_w[g]),
            .fall_o(fall_w[g])
        );
    end

    assign fall_a_w  = fall_w[0];
    assign fall_b_w  = fall_w[1];
    assign clr_w     = clr_a_i & clr_b_i;
    assign up_step_w = chain_i ? carry_w : fall_b_w;

    div12_toggle_stage u_tog (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .clr_i  (clr_w),
        .step_i (fall_a_w),
        .bit_o  (q0_w),
        .carry_o(carry_w)
    );

    div12_hex_stage u_hex (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .clr_i (clr_w),
        .step_i(up_step_w),
        .code_o(up_w)
    );

    assign q_o  = {up_w, q0_w};
    assign tc_o = chain_i & (q_o == LAST_CHAINED);
endmodule

// File: rtl/div12_counter_chk.sv
module div12_counter_chk (
    input logic       clk_i,
    input logic       rst_n,
    input logic       clr_a_i,
    input logic       clr_b_i,
    input logic       chain_i,
    input logic [3:0] q_o,
    input logic       fall_a_i,
    input logic       up_step_i
);
    // R7
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (clr_a_i && clr_b_i) |=> (q_o == 4'b0000));

    // R3
    code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        q_o[2:1] != 2'b11);

    // R2
    q0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!(clr_a_i && clr_b_i) && !fall_a_i) |=> $stable(q_o[0]));

    // R4
    up_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (!(clr_a_i && clr_b_i) && !up_step_i) |=> $stable(q_o[3:1]));

    // R3
    q3_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (up_step_i && !(clr_a_i && clr_b_i) && q_o[2:1] == 2'b10)
        |=> (q_o[2:1] == 2'b00 && q_o[3] != $past(q_o[3])));

    // R5
    chain_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        (chain_i && fall_a_i && q_o[0] && !(clr_a_i && clr_b_i))
        |=> !$stable(q_o[3:1]));
endmodule

bind div12_counter div12_counter_chk u_chk (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .clr_a_i  (clr_a_i),
    .clr_b_i  (clr_b_i),
    .chain_i  (chain_i),
    .q_o      (q_o),
    .fall_a_i (fall_a_w),
    .up_step_i(up_step_w)
);

// File: tb/div12_counter_bench.sv
`timescale 1ns/1ps
module div12_counter_bench;
    logic       clk_i = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_a_i = 1'b0;
    logic       cnt_b_i = 1'b0;
    logic       clr_a_i = 1'b0;
    logic       clr_b_i = 1'b0;
    logic       chain_i = 1'b0;
    logic [3:0] q_o;
    logic       tc_o;

    int vectors = 0;
    int misses  = 0;
    int ek      = 0;   // expected upper-stage step index 0..5
    bit eq0     = 1'b0;

    always #5 clk_i = ~clk_i;

    div12_counter u_div12_counter (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .cnt_a_i(cnt_a_i),
        .cnt_b_i(cnt_b_i),
        .clr_a_i(clr_a_i),
        .clr_b_i(clr_b_i),
        .chain_i(chain_i),
        .q_o    (q_o),
        .tc_o   (tc_o)
    );

    function automatic logic [3:0] code_of(int k, bit q0);
        int m = k % 6;
        return {(m >= 3), ((m % 3) == 2), ((m % 3) == 1), q0};
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic pulse_a();
        @(negedge clk_i) cnt_a_i = 1'b1;
        repeat (4) @(negedge clk_i);
        cnt_a_i = 1'b0;
        repeat (4) @(negedge clk_i);
    endtask

    task automatic pulse_b();
        @(negedge clk_i) cnt_b_i = 1'b1;
        repeat (4) @(negedge clk_i);
        cnt_b_i = 1'b0;
        repeat (4) @(negedge clk_i);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        #2_000_000;
        misses++;
        $display("FAIL watchdog R1 got=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk_i);
        check("R1 q", q_o, 4'b0000);
        check("R1 tc", {3'b0, tc_o}, 4'b0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_i);

        // R2 rising edge has no effect, falling edge lands on third clock
        cnt_a_i = 1'b1;
        repeat (4) @(negedge clk_i);
        check("R2 rise", q_o, 4'b0000);
        cnt_a_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        check("R2 early", q_o, 4'b0000);
        @(negedge clk_i);
        eq0 = 1'b1;
        check("R2 third", q_o, code_of(ek, eq0));
        repeat (2) @(negedge clk_i);

        // R3 independent upper-stage sweep, Q0 untouched
        for (int i = 0; i < 12; i++) begin
            pulse_b();
            ek = (ek + 1) % 6;
            check("R3 seq", q_o, code_of(ek, eq0));
        end

        // R4 cnt_a in independent mode leaves upper stage alone
        for (int i = 0; i < 2; i++) begin
            pulse_a();
            eq0 = ~eq0;
            check("R4 indep", q_o, code_of(ek, eq0));
        end

        // R8 reach 1101 in independent mode
        for (int i = 0; i < 5; i++) begin
            pulse_b();
            ek = (ek + 1) % 6;
        end
        check("R8 state", q_o, 4'b1101);
        check("R8 tc off", {3'b0, tc_o}, 4'b0000);
        chain_i = 1'b1;
        #1;
        check("R8 tc on", {3'b0, tc_o}, 4'b0001);

        // R7 single leg of clear is ignored
        @(negedge clk_i) clr_a_i = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R7 leg a", q_o, 4'b1101);
        clr_a_i = 1'b0; clr_b_i = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R7 leg b", q_o, 4'b1101);
        clr_a_i = 1'b1;
        @(negedge clk_i);
        check("R7 both", q_o, 4'b0000);
        pulse_a();
        check("R7 hold", q_o, 4'b0000);
        clr_a_i = 1'b0; clr_b_i = 1'b0;
        ek = 0; eq0 = 1'b0;
        repeat (2) @(negedge clk_i);

        // R5 R6 R8 chained sweep over two full periods
        for (int n = 1; n <= 24; n++) begin
            int c;
            pulse_a();
            c = n % 12;
            check("R5 seq", q_o, code_of(c / 2, c[0]));
            check("R6 q3", {3'b0, q_o[3]}, {3'b0, (c >= 6)});
            check("R8 tc", {3'b0, tc_o}, {3'b0, (c == 11)});
        end

        // R4 cnt_b ignored in chained mode
        pulse_a();
        check("R4 pre", q_o, 4'b0001);
        pulse_b();
        check("R4 chained b", q_o, 4'b0001);

        summary();
        $finish;
    end
endmodule